// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

A full-duplex asynchronous serial port configured through a single control register. Software writes characters into a transmit holding register and collects received characters from a receive buffer; a status register reports whether the holding register can take another character, whether unread data is waiting, and whether the last characters had parity or framing faults. Bit timing comes from an external tick that runs at sixteen times the bit rate.

A 3-bit format field selects one of four character formats. Two of them can optionally replace the top data bit with a parity bit of selectable sense. One 9-bit format serves multi-drop addressing: the receiver keeps only characters whose ninth bit is high. The transmitter and the receiver are enabled separately. Two interrupt request outputs are levels that follow the status flags for as long as the flags and their enables stay set.

Top module: `mm_serial_port`

## Requirements
- R1: After reset the control register reads 0, the status register reads 9'h002 (only the transmit-empty flag set), txd is high and both interrupt outputs are low.
- R2: Address 0 is the control register, read and write: bit 8 transmit interrupt enable, bit 7 receive interrupt enable, bit 6 transmitter enable, bit 5 receiver enable, bit 4 even-parity select, bit 3 parity enable, bits 2:0 format. Address 1 is status (bit 0 data ready, bit 1 transmit empty, bit 2 parity error, bit 3 framing error, upper bits 0). Writing address 2 loads the transmit holding register. Reading address 3 returns the receive buffer.
- R3: Every frame is one low start bit, the character bits least significant first, and one high stop bit, with each bit lasting 16 ticks. Format 1 carries 8 character bits, formats 2 and 3 carry 9, and format 4 carries 7.
- R4: With parity enabled in format 1 or 3, the top character bit becomes a parity bit computed over the bits below it: even select gives an even count of ones over data and parity, odd select an odd count. Parity enable and sense have no effect in formats 2 and 4.
- R5: Writing the holding register clears transmit-empty. The character moves to the shifter only while the transmitter is enabled, the format is valid and no frame is in progress, and transmit-empty sets again at that moment.
- R6: tx_irq is high exactly while the transmit interrupt enable, the transmitter enable and transmit-empty are all set, and it stays high for as long as they do.
- R7: rx_irq is high while the receive interrupt enable and data ready are set and stays high until the buffer is read. Reading address 3 clears data ready.
- R8: The receiver starts on a falling edge of rxd, samples each bit 8 ticks into it, and returns to idle without a character if the start bit is high at that point. With the receiver disabled the line is ignored.
- R9: In format 2 a character whose ninth bit is low is discarded: data ready, the buffer and both error flags stay unchanged.
- R10: A character with wrong parity sets the parity error flag. A stop bit sampled low sets the framing error flag and the character is still stored. Reading the status register clears both error flags.
- R11: The receive buffer holds the character right-justified, with the parity bit position reading 0 and bits above the character length reading 0.
- R12: Formats 0, 5, 6 and 7 are reserved: nothing is transmitted and nothing is received while one of them is selected, and a pending character stays in the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, triggers read side effects |
| addr | input | 2 | Register address |
| wdata | input | 9 | Write data |
| rdata | output | 9 | Read data, combinational from addr |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |
| tx_irq | output | 1 | Transmit interrupt request level |
| rx_irq | output | 1 | Receive interrupt request level |

## Verification
The assertions assume that the control register is not rewritten while a frame is being shifted in either direction, that baud_tick is a single-cycle pulse, and that rxd holds each bit for a full 16 ticks. The bench writes control only between frames, pulses the tick on every other clock, and drives rxd frames with exact bit periods. A sweep covers every valid format with both parity settings and both senses, in both directions, with bad parity, a low ninth bit, a low stop bit and a short glitch as the corner cases.

// File: rtl/mm_serial_port.sv
module mm_serial_port #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [8:0] wdata,
  output logic [8:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2 - 1);

  logic [8:0] ctrl, thr, rbuf;
  logic       thre, rdr, perr, ferr;

  wire       txie = ctrl[8];
  wire       rxie = ctrl[7];
  wire       txen = ctrl[6];
  wire       rxen = ctrl[5];
  wire       evn  = ctrl[4];
  wire       pen  = ctrl[3];
  wire [2:0] fmt  = ctrl[2:0];

  wire mode_ok = (fmt != 3'd0) && (fmt < 3'd5);
  wire par_on  = pen && (fmt == 3'd1 || fmt == 3'd3);

  logic [3:0] nbits;
  always_comb
    case (fmt)
      3'd2, 3'd3: nbits = 4'd9;
      3'd4:       nbits = 4'd7;
      default:    nbits = 4'd8;
    endcase

  wire [3:0] pidx = nbits - 4'd1;
  wire [8:0] cmask = 9'((10'd1 << nbits) - 10'd1);

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire wr_thr  = wr_en && addr == 2'd2;
  wire rd_stat = rd_en && addr == 2'd1;
  wire rd_buf  = rd_en && addr == 2'd3;

  // transmit side
  logic [8:0]    tx_word;
  logic [10:0]   tx_sh;
  logic [SW-1:0] tx_sub;
  logic [3:0]    tx_left;
  logic          tx_busy;

  always_comb begin
    tx_word = thr & cmask;
    if (par_on) begin
      tx_word[pidx] = 1'b0;
      tx_word[pidx] = (^tx_word) ^ ~evn;
    end
    tx_word = tx_word | ~cmask;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr     <= '0;
      thre    <= 1'b1;
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_sub  <= '0;
      tx_left <= '0;
    end else begin
      if (!txen) tx_busy <= 1'b0;
      else if (!tx_busy) begin
        if (!thre && mode_ok) begin
          tx_busy <= 1'b1;
          tx_sh   <= {1'b1, tx_word, 1'b0};
          tx_sub  <= '0;
          tx_left <= nbits + 4'd2;
          thre    <= 1'b1;
        end
      end else if (baud_tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == LAST) begin
          tx_sub  <= '0;
          tx_sh   <= {1'b1, tx_sh[10:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end
      if (wr_thr) begin
        thr  <= wdata;
        thre <= 1'b0;
      end
    end

  assign txd    = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_irq = txie & txen & thre;

  // receive side
  logic          rx_s1, rx_s2, rx_prev, rx_busy;
  logic [SW-1:0] rx_sub;
  logic [3:0]    rx_idx;
  logic [8:0]    rx_sh;

  wire [8:0] rx_al   = rx_sh >> (4'd9 - nbits);
  wire       rx_bad  = par_on && ((^rx_al) ^ ~evn);
  wire [8:0] rx_data = par_on ? (rx_al & ~(9'd1 << pidx)) : rx_al;
  wire       rx_keep = !(fmt == 3'd2 && !rx_al[8]);
  wire       rx_en_ok = rxen && mode_ok;
  wire       rx_done = rx_en_ok && rx_busy && baud_tick && rx_sub == MID && rx_idx > nbits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_prev <= 1'b1;
      rx_busy <= 1'b0;
      rx_sub  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rbuf    <= '0;
      rdr     <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      rx_s1   <= rxd;
      rx_s2   <= rx_s1;
      rx_prev <= rx_s2;
      if (rd_buf) rdr <= 1'b0;
      if (rd_stat) begin
        perr <= 1'b0;
        ferr <= 1'b0;
      end
      if (!rx_en_ok) rx_busy <= 1'b0;
      else if (!rx_busy) begin
        if (rx_prev && !rx_s2) begin
          rx_busy <= 1'b1;
          rx_sub  <= '0;
          rx_idx  <= '0;
          rx_sh   <= '0;
        end
      end else if (baud_tick) begin
        rx_sub <= (rx_sub == LAST) ? '0 : rx_sub + 1'b1;
        if (rx_sub == MID) begin
          rx_idx <= rx_idx + 4'd1;
          if (rx_idx == 4'd0) begin
            if (rx_s2) rx_busy <= 1'b0;
          end else if (rx_idx <= nbits) begin
            rx_sh <= {rx_s2, rx_sh[8:1]};
          end else begin
            rx_busy <= 1'b0;
            if (rx_keep) begin
              rbuf <= rx_data;
              rdr  <= 1'b1;
              if (rx_bad) perr <= 1'b1;
              if (!rx_s2) ferr <= 1'b1;
            end
          end
        end
      end
    end

  assign rx_irq = rxie & rdr;

  // register file
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= wdata;

  always_comb
    case (addr)
      2'd0:    rdata = ctrl;
      2'd1:    rdata = {5'd0, ferr, perr, thre, rdr};
      2'd2:    rdata = thr;
      default: rdata = rbuf;
    endcase

  AST_THRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && !$past(wr_thr)) |-> thre); // R5
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_left == 4'd1) |-> txd); // R3
  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!txen && !wr_ctrl) |=> (!tx_busy && !tx_irq)); // R6
  AST_RDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !rx_done) |=> !rdr); // R7
  AST_RXIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rd_buf && !wr_ctrl) |=> rx_irq); // R7
  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdr) && fmt == 3'd2 && $stable(ctrl)) |-> rbuf[8]); // R9
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxen && !wr_ctrl) |=> !rx_busy); // R8
endmodule

// File: tb/mm_serial_port_test.sv
module mm_serial_port_test;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic       txd, tx_irq, rx_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  initial forever begin
    @(posedge clk);
    baud_tick <= ~baud_tick;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [8:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int nb(input int f);
    return (f == 2 || f == 3) ? 9 : (f == 4) ? 7 : 8;
  endfunction

  function automatic bit has_par(input int f, input bit pe);
    return pe && (f == 1 || f == 3);
  endfunction

  function automatic logic [8:0] enc(input int f, input bit pe, input bit ev, input logic [8:0] d);
    int n = nb(f);
    logic [8:0] b = d & 9'((1 << n) - 1);
    if (has_par(f, pe)) begin
      b[n-1] = 1'b0;
      b[n-1] = (^b) ^ !ev;
    end
    return b;
  endfunction

  task automatic tx_capture(input string tag, input int n, input logic [8:0] exp);
    int w = 0;
    while (txd && w < 3000) begin @(negedge clk); w++; end
    chk({tag, " start seen"}, (w < 3000), 1);
    repeat (16) @(negedge clk);
    chk({tag, " start low"}, txd, 0);
    for (int i = 0; i < n; i++) begin
      repeat (32) @(negedge clk);
      chk({tag, " data bit"}, txd, exp[i]);
    end
    repeat (32) @(negedge clk);
    chk({tag, " stop high R3"}, txd, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic rx_send(input int n, input logic [8:0] bits, input bit stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      repeat (32) @(negedge clk);
    end
    rxd = stopv;
    repeat (32) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] v, d, bits, expd;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 status", v, 9'h002);
    chk("R1 txd", txd, 1);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);

    // R2 control readback
    wr(2'd0, 9'h1AB);
    rd(2'd0, v); chk("R2 ctrl readback", v, 9'h1AB);
    wr(2'd0, 9'h000);

    // R3 R4 R5 R9 R10 R11 sweep over formats, parity settings and values
    for (int f = 1; f <= 4; f++)
      for (int pe = 0; pe < 2; pe++)
        for (int ev = 0; ev < 2; ev++)
          for (int k = 0; k < 2; k++) begin
            d = {k[0], 8'(8'h5A + f * 8'h1D + pe * 8'h33 + ev * 8'h47 + k * 8'h81)};
            wr(2'd0, {3'b001, 1'b0, ev[0], pe[0], 3'(f)});
            wr(2'd2, d);
            rd(2'd1, v); chk("R5 thre after load", v[1], 1);
            tx_capture("R3 R4 tx", nb(f), enc(f, pe[0], ev[0], d));

            wr(2'd0, {3'b000, 1'b1, ev[0], pe[0], 3'(f)});
            bits = enc(f, pe[0], ev[0], d);
            if (has_par(f, pe[0]) && k == 1) bits[nb(f)-1] = ~bits[nb(f)-1];
            rx_send(nb(f), bits, 1'b1);
            rd(2'd1, v);
            if (f == 2 && !d[8]) begin
              chk("R9 dropped rdr", v[0], 0);
              chk("R9 dropped errors", v[3:2], 0);
            end else begin
              chk("R8 rdr set", v[0], 1);
              chk("R10 parity flag", v[2], has_par(f, pe[0]) && k == 1);
              chk("R10 framing flag", v[3], 0);
              expd = d & 9'((1 << nb(f)) - 1);
              if (has_par(f, pe[0])) expd[nb(f)-1] = 1'b0;
              rd(2'd3, v); chk("R11 buffer", v, expd);
              rd(2'd1, v); chk("R7 R10 cleared", v & 9'h00D, 0);
            end
          end

    // R5 R6: holding register waits while transmitter disabled
    wr(2'd0, 9'h101);
    chk("R6 irq gated by enable", tx_irq, 0);
    wr(2'd2, 9'h03C);
    rd(2'd1, v); chk("R5 thre cleared", v[1], 0);
    lows = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R5 no tx when disabled", lows, 0);
    wr(2'd0, 9'h141);
    tx_capture("R5 tx", 8, 9'h03C);
    chk("R6 irq high", tx_irq, 1);
    repeat (40) @(negedge clk);
    chk("R6 irq held", tx_irq, 1);
    wr(2'd0, 9'h101);
    chk("R6 irq off with txen", tx_irq, 0);

    // R7 receive interrupt level
    wr(2'd0, 9'h0A1);
    rx_send(8, 9'h0C5, 1'b1);
    chk("R7 irq high", rx_irq, 1);
    repeat (50) @(negedge clk);
    chk("R7 irq held", rx_irq, 1);
    rd(2'd3, v); chk("R7 data", v, 9'h0C5);
    chk("R7 irq cleared", rx_irq, 0);

    // R8 glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (700) @(negedge clk);
    rd(2'd1, v); chk("R8 glitch ignored", v[0], 0);

    // R8 receiver disabled
    wr(2'd0, 9'h001);
    rx_send(8, 9'h055, 1'b1);
    rd(2'd1, v); chk("R8 disabled rx", v[0], 0);

    // R10 framing error, character kept
    wr(2'd0, 9'h021);
    rx_send(8, 9'h0A7, 1'b0);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R10 framing set", v[3], 1); chk("R10 rdr with framing", v[0], 1);
    rd(2'd1, v); chk("R10 framing cleared", v[3], 0);
    rd(2'd3, v); chk("R10 framed data", v, 9'h0A7);

    // R12 reserved formats
    wr(2'd0, 9'h065);
    wr(2'd2, 9'h0E1);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R12 no tx", lows, 0);
    rd(2'd1, v); chk("R12 thre stays clear", v[1], 0);
    rx_send(8, 9'h033, 1'b1);
    rd(2'd1, v); chk("R12 no rx", v[0], 0);
    wr(2'd0, 9'h041);
    tx_capture("R12 pending sent", 8, 9'h0E1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule